// File: doc/BRIEF.md
# Link Silence and Idle Watchdog

This block manages the start-up and liveness of one serial link lane. It runs on the lane byte clock, which is the link bit rate divided by 20. A programmable divider turns that clock into a slower service tick, and both timers in the block count in service ticks.

After reset the block is silent, with the transmit driver held off. The partner then loses lane sync and has to reinitialize. The silent period lasts 410 service ticks for each unit of the silence count. It must be long enough for the partner to drop sync, but short enough that the partner does not take it for a broken link.

When the silent period ends, the block turns the driver on and starts an idle watchdog. Each received IDLE symbol restarts the watchdog from zero. If 3 × the timeout count service ticks pass with no IDLE, the block raises a sticky link-fault flag and goes back to silence to start the link again. Lane alignment and symbol decoding happen elsewhere. This block only sees a one-cycle IDLE-received strobe.

Top module: `link_silence_watchdog`

## Requirements
- R1: While reset is asserted and right after it, `drv_en` is 0, `link_state` is 0 (silent) and `link_fault` is 0.
- R2: The silent state lasts exactly 410 × N service ticks, where N is `sil_val`. On the clock edge that completes the last tick, `link_state` becomes 1 (active).
- R3: A service tick occurs once every max(`div_val`,1) byte clocks. The tick counter runs freely from reset, so the first tick falls on edge max(`div_val`,1) after reset is released.
- R4: In the active state, a watchdog expiry happens on the tick that completes 3 × M consecutive service ticks with no IDLE strobe, where M is `lto_val`. On that edge `link_state` returns to 0 and `drv_en` goes to 0.
- R5: A value of zero in `sil_val` behaves as one, and so does a zero in `lto_val`.
- R6: Once set, `link_fault` stays at 1 until reset, including through the following silent and active periods.
- R7: An `idle_rx` strobe in the active state restarts the watchdog count from zero on that edge. No fault can be raised on an edge where `idle_rx` is high.
- R8: After a fault, the block spends a full new silent period of 410 × N ticks and then becomes active again.
- R9: `idle_rx` strobes during the silent state do not shorten or lengthen the silent period.
- R10: `drv_en` is 1 exactly when `link_state` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | DIV_W | Service-tick divider (0 acts as 1) |
| sil_val | input | SIL_W | Silent duration in units of 410 ticks (0 acts as 1) |
| lto_val | input | LTO_W | Watchdog window in units of 3 ticks (0 acts as 1) |
| idle_rx | input | 1 | One-cycle strobe for each received IDLE symbol |
| drv_en | output | 1 | Transmit driver enable |
| link_state | output | 1 | 0 = silent, 1 = active |
| link_fault | output | 1 | Sticky flag set by a watchdog expiry |

## Verification
The bench samples the exact edge on which each timer ends, and also the edge before it. An off-by-one in either counter, or a silent period that counts byte clocks instead of ticks, shows up as a state change one edge early or late. Zero counts and a zero divider are each driven on their own. A design that took zero literally would either never leave silence or fault at once. The bench also checks IDLE strobes sent during silence, which a careless design lets into the timers, and a fault followed by recovery. A non-sticky flag clears at that recovery, and a silence counter that is not cleared on re-entry shortens the second silent period.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
   typedef enum logic {
      LNK_SILENT = 1'b0,
      LNK_ACTIVE = 1'b1
   } lnk_state_e;
endpackage

// File: rtl/lsw_tick_div.sv
// Service-tick divider: one tick every max(div_val,1) byte clocks.
module lsw_tick_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] eff_div;

   initial begin
      assert (DIV_W >= 1) else $error("lsw_tick_div: DIV_W must be at least 1");
   end

   assign eff_div = (div_val == '0) ? DIV_W'(1) : div_val;
   assign tick    = (cnt_q >= eff_div - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
   end

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && eff_div != DIV_W'(1) && $stable(div_val)) |=> !tick);
endmodule

// File: rtl/lsw_silence_timer.sv
// Counts service ticks during the silent state, 410 ticks per unit.
module lsw_silence_timer #(
   parameter int SIL_W    = 4,
   parameter int SIL_UNIT = 410
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [SIL_W-1:0] sil_val,
   output logic             done
);
   localparam int SIL_CW = SIL_W + $clog2(SIL_UNIT + 1);

   logic [SIL_CW-1:0] cnt_q;
   logic [SIL_CW-1:0] target;
   logic [SIL_W-1:0]  eff_sil;

   initial begin
      assert (SIL_UNIT >= 1) else $error("lsw_silence_timer: SIL_UNIT must be positive");
      assert (SIL_W >= 1)    else $error("lsw_silence_timer: SIL_W must be at least 1");
   end

   assign eff_sil = (sil_val == '0) ? SIL_W'(1) : sil_val;
   assign target  = SIL_CW'(eff_sil) * SIL_CW'(SIL_UNIT);
   assign done    = run && tick && (cnt_q >= target - SIL_CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || done) cnt_q <= '0;
      else if (tick)         cnt_q <= cnt_q + SIL_CW'(1);
   end

   // R2
   silence_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);
endmodule

// File: rtl/lsw_idle_watchdog.sv
// Counts service ticks since the last IDLE; expires after 3*M ticks.
module lsw_idle_watchdog #(
   parameter int LTO_W    = 8,
   parameter int LTO_UNIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             tick,
   input  logic             idle_rx,
   input  logic [LTO_W-1:0] lto_val,
   output logic             expire
);
   localparam int LTO_CW = LTO_W + $clog2(LTO_UNIT + 1);

   logic [LTO_CW-1:0] cnt_q;
   logic [LTO_CW-1:0] target;
   logic [LTO_W-1:0]  eff_lto;

   initial begin
      assert (LTO_UNIT >= 1) else $error("lsw_idle_watchdog: LTO_UNIT must be positive");
      assert (LTO_W >= 1)    else $error("lsw_idle_watchdog: LTO_W must be at least 1");
   end

   assign eff_lto = (lto_val == '0) ? LTO_W'(1) : lto_val;
   assign target  = LTO_CW'(eff_lto) * LTO_CW'(LTO_UNIT);
   assign expire  = armed && tick && !idle_rx && (cnt_q >= target - LTO_CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!armed || idle_rx || expire) cnt_q <= '0;
      else if (tick)                       cnt_q <= cnt_q + LTO_CW'(1);
   end

   // R4
   wd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

// File: rtl/link_silence_watchdog.sv
module link_silence_watchdog
   import lsw_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int SIL_W    = 4,
   parameter int LTO_W    = 8,
   parameter int SIL_UNIT = 410,
   parameter int LTO_UNIT = 3,
   parameter bit REG_DRV  = 1'b1
) (
   input  logic             byte_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic [SIL_W-1:0] sil_val,
   input  logic [LTO_W-1:0] lto_val,
   input  logic             idle_rx,
   output logic             drv_en,
   output logic             link_state,
   output logic             link_fault
);
   lnk_state_e state_q, state_d;
   logic       tick, sil_done, wd_exp, fault_q;

   lsw_tick_div #(.DIV_W(DIV_W)) u_tick (
      .clk(byte_clk), .rst_n(rst_n), .div_val(div_val), .tick(tick));

   lsw_silence_timer #(.SIL_W(SIL_W), .SIL_UNIT(SIL_UNIT)) u_sil (
      .clk(byte_clk), .rst_n(rst_n), .run(state_q == LNK_SILENT),
      .tick(tick), .sil_val(sil_val), .done(sil_done));

   lsw_idle_watchdog #(.LTO_W(LTO_W), .LTO_UNIT(LTO_UNIT)) u_wd (
      .clk(byte_clk), .rst_n(rst_n), .armed(state_q == LNK_ACTIVE),
      .tick(tick), .idle_rx(idle_rx), .lto_val(lto_val), .expire(wd_exp));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LNK_SILENT: if (sil_done) state_d = LNK_ACTIVE;
         LNK_ACTIVE: if (wd_exp)   state_d = LNK_SILENT;
         default:    state_d = LNK_SILENT;
      endcase
   end

   always_ff @(posedge byte_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LNK_SILENT;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fault_q <= fault_q | wd_exp;
      end
   end

   generate
      if (REG_DRV) begin : g_drv_reg
         logic drv_q;
         always_ff @(posedge byte_clk or negedge rst_n) begin
            if (!rst_n) drv_q <= 1'b0;
            else        drv_q <= (state_d == LNK_ACTIVE);
         end
         assign drv_en = drv_q;
      end else begin : g_drv_comb
         assign drv_en = (state_q == LNK_ACTIVE);
      end
   endgenerate

   assign link_state = state_q;
   assign link_fault = fault_q;

   // R2
   silent_hold_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
      (state_q == LNK_SILENT && !sil_done) |=> state_q == LNK_SILENT);
   // R4
   expire_to_silent_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
      wd_exp |=> (state_q == LNK_SILENT && link_fault && !drv_en));
   // R6
   fault_sticky_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
      link_fault |=> link_fault);
   // R7
   idle_blocks_fault_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
      (idle_rx && !link_fault) |=> !link_fault);
   // R10
   drv_match_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
      drv_en == link_state);
endmodule

// File: tb/test_link_silence_watchdog.sv
module test_link_silence_watchdog;
   logic       byte_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_val = 8'd1;
   logic [3:0] sil_val = 4'd1;
   logic [7:0] lto_val = 8'd1;
   logic       idle_rx = 1'b0;
   logic       drv_en, link_state, link_fault;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   link_silence_watchdog i_link_silence_watchdog (
      .byte_clk(byte_clk), .rst_n(rst_n), .div_val(div_val), .sil_val(sil_val),
      .lto_val(lto_val), .idle_rx(idle_rx), .drv_en(drv_en),
      .link_state(link_state), .link_fault(link_fault));

   // 50 MHz: 20 ns period
   always #10 byte_clk = ~byte_clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge byte_clk);
      @(negedge byte_clk);
   endtask

   task automatic start(input int d, input int s, input int l);
      idle_rx = 1'b0;
      @(negedge byte_clk);
      rst_n   = 1'b0;
      div_val = 8'(d); sil_val = 4'(s); lto_val = 8'(l);
      step(2);
      rst_n = 1'b1;
   endtask

   // state must still be silent after edge t-1 and active after edge t
   task automatic expect_active_at(input string req, input int t);
      step(t - 1);
      check({req, " silent before end"}, int'(link_state), 0);
      check({req, " driver off before end"}, int'(drv_en), 0);
      step(1);
      check({req, " active at end"}, int'(link_state), 1);
      check({req, " R10 driver on"}, int'(drv_en), 1);
   endtask

   task automatic expect_fault_after(input string req, input int n);
      step(n - 1);
      check({req, " no fault yet"}, int'(link_fault), 0);
      step(1);
      check({req, " fault set"}, int'(link_fault), 1);
      check({req, " back to silent"}, int'(link_state), 0);
      check({req, " R10 driver off"}, int'(drv_en), 0);
   endtask

   task automatic t_reset();
      start(1, 1, 1);
      check("R1 state", int'(link_state), 0);
      check("R1 driver", int'(drv_en), 0);
      check("R1 fault", int'(link_fault), 0);
   endtask

   task automatic t_silence();
      start(1, 1, 5);  expect_active_at("R2 one unit", 410);
      start(1, 2, 5);  expect_active_at("R2 two units", 820);
      start(1, 0, 5);  expect_active_at("R5 zero silence", 410);
   endtask

   task automatic t_divider();
      start(4, 1, 5);  expect_active_at("R3 div4", 1640);
      start(0, 1, 5);  expect_active_at("R3 div0", 410);
      start(2, 1, 1);  expect_active_at("R3 div2", 820);
      expect_fault_after("R3 div2 watchdog", 6);
   endtask

   task automatic t_watchdog();
      start(1, 1, 5);  expect_active_at("R4 setup", 410);
      expect_fault_after("R4 window", 15);
      start(1, 1, 0);  expect_active_at("R5 setup", 410);
      expect_fault_after("R5 zero timeout", 3);
   endtask

   task automatic t_idle_restart();
      start(1, 1, 5);  expect_active_at("R7 setup", 410);
      for (int i = 0; i < 10; i++) begin
         step(9); idle_rx = 1'b1; step(1); idle_rx = 1'b0;
      end
      check("R7 regular idles keep link", int'(link_fault), 0);
      check("R7 still active", int'(link_state), 1);
      step(9); idle_rx = 1'b1; step(1); idle_rx = 1'b0;
      expect_fault_after("R7 restart from idle", 15);
   endtask

   task automatic t_recover();
      start(1, 1, 1);  expect_active_at("R8 setup", 410);
      expect_fault_after("R8 first fault", 3);
      step(409);
      check("R8 full silence again", int'(link_state), 0);
      check("R6 sticky in silence", int'(link_fault), 1);
      step(1);
      check("R8 active again", int'(link_state), 1);
      check("R6 sticky when active", int'(link_fault), 1);
      idle_rx = 1'b1; step(1); idle_rx = 1'b0;
      check("R6 sticky after idle", int'(link_fault), 1);
   endtask

   task automatic t_idle_in_silence();
      start(1, 1, 5);
      idle_rx = 1'b1;
      step(409);
      check("R9 idle ignored early", int'(link_state), 0);
      step(1);
      check("R9 idle ignored end", int'(link_state), 1);
      idle_rx = 1'b0;
      check("R9 no fault", int'(link_fault), 0);
   endtask

   initial begin
      t_reset();
      t_silence();
      t_divider();
      t_watchdog();
      t_idle_restart();
      t_recover();
      t_idle_in_silence();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge byte_clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule